// File: doc/BRIEF.md
# PCI Hotplug Event Controller

This block holds the registers through which system firmware learns that a device was inserted into or removed from one slot of a 32-slot PCI bus. A hotplug source raises a one-cycle event strobe carrying the slot number and whether the device arrived or left. The block records the slot in an "arrived" or "departed" bitmap and latches a hotplug status flag in a general-purpose event (GPE) status byte. When firmware has enabled that flag, an interrupt request goes high.

Firmware reads and writes the registers through a simple single-cycle port. The GPE status and enable bytes are accessed one byte at a time. The two slot bitmaps are full 32-bit words. Firmware can also write an eject command, which the block turns into a one-cycle eject strobe for the slot named by the lowest set bit of the written word. A fixed-slot input marks devices that must never be removed. Such slots are never ejected, and they read back as cleared bits in a read-only removable-slots mask. Tearing down the device is left to the logic that receives the eject strobe.

Top module: `hotplug_evt_ctrl`

## Requirements
- R1: After reset the status byte, both enable bytes and both bitmaps read 0. gpe_irq and eject_stb are low.
- R2: Addresses 0x00 and 0x01 are the status bytes. Addresses 0x02 and 0x03 are the enable bytes. Each byte uses reg_wdata[7:0] and reads back zero-extended. Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. Enable bytes read back exactly what was written.
- R3: gpe_irq is high exactly when bit 1 (value 0x02) of status byte 0x00 and bit 1 of enable byte 0x02 are both set. It changes on the same clock edge as the registers it depends on.
- R4: An insertion event (evt_valid=1, evt_insert=1, evt_cold=0) for slot s does three things at the next edge: the arrived bitmap becomes exactly 1<<s, the departed bitmap becomes 0, and status bit 1 of byte 0x00 is set.
- R5: A removal event (evt_valid=1, evt_insert=0) for slot s does three things at the next edge: the departed bitmap becomes exactly 1<<s, the arrived bitmap becomes 0, and status bit 1 is set.
- R6: An insertion flagged as present at power-on (evt_insert=1, evt_cold=1) changes no register and raises no interrupt.
- R7: The arrived bitmap at 0x10 and the departed bitmap at 0x14 are 32-bit read/write words. If an event and a register write land on the same edge, the event result wins. This applies to bitmap writes and to status-clear writes.
- R8: A nonzero write to 0x18 picks the slot k of the lowest set bit of the data. If fixed_slots[k] is 0, eject_stb is high for exactly the cycle after the write, with eject_slot equal to k. If fixed_slots[k] is 1, no strobe is raised. A read of 0x18 returns 0.
- R9: A write of zero to 0x18 raises no eject strobe.
- R10: A read of 0x1C returns ~fixed_slots. Writes to 0x1C change no register.
- R11: Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle hotplug event strobe |
| evt_slot | input | 5 | Slot number of the event |
| evt_insert | input | 1 | 1 = device arrived, 0 = device departed |
| evt_cold | input | 1 | Arrival of a device present at power-on; suppresses the event |
| fixed_slots | input | 32 | Bit n set: slot n holds a device that cannot be removed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| gpe_irq | output | 1 | Event interrupt request |
| eject_stb | output | 1 | One-cycle eject command |
| eject_slot | output | 5 | Slot to eject, valid with eject_stb |

## Verification
The hardest situations to reach are an event landing on the same edge as a firmware write that targets the state the event also changes: a status-clear write, or a bitmap write. Random stimulus issues events and writes independently in every cycle, so these collisions occur many times, and directed cycles force both kinds once. Eject data with several bits set, where the lowest one names a fixed slot, is also driven directly. This checks that the block blocks the strobe rather than moving on to the next set bit.

// File: rtl/hotplug_evt_ctrl.sv
module hotplug_evt_ctrl #(
  parameter int SLOTS  = 32,
  parameter int HP_BIT = 1,
  parameter int AW     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  input  logic [$clog2(SLOTS)-1:0] evt_slot,
  input  logic                     evt_insert,
  input  logic                     evt_cold,
  input  logic [SLOTS-1:0]         fixed_slots,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [SLOTS-1:0]         reg_wdata,
  output logic [SLOTS-1:0]         reg_rdata,
  output logic                     gpe_irq,
  output logic                     eject_stb,
  output logic [$clog2(SLOTS)-1:0] eject_slot
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [AW-1:0] A_STS0 = AW'(0);
  localparam logic [AW-1:0] A_STS1 = AW'(1);
  localparam logic [AW-1:0] A_EN0  = AW'(2);
  localparam logic [AW-1:0] A_EN1  = AW'(3);
  localparam logic [AW-1:0] A_UP   = AW'(16);
  localparam logic [AW-1:0] A_DN   = AW'(20);
  localparam logic [AW-1:0] A_EJ   = AW'(24);
  localparam logic [AW-1:0] A_RM   = AW'(28);

  logic             sts_hp;
  logic [7:0]       en0, en1;
  logic [SLOTS-1:0] up_q, dn_q;
  logic [SW-1:0]    ej_idx;
  logic             hot_evt;

  assign hot_evt = evt_valid && !(evt_insert && evt_cold);

  always_comb begin
    ej_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (reg_wdata[i]) ej_idx = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_hp     <= 1'b0;
      en0        <= '0;
      en1        <= '0;
      up_q       <= '0;
      dn_q       <= '0;
      eject_stb  <= 1'b0;
      eject_slot <= '0;
    end else begin
      eject_stb <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_STS0: if (reg_wdata[HP_BIT]) sts_hp <= 1'b0;
          A_EN0:  en0 <= reg_wdata[7:0];
          A_EN1:  en1 <= reg_wdata[7:0];
          A_UP:   up_q <= reg_wdata;
          A_DN:   dn_q <= reg_wdata;
          A_EJ: if (reg_wdata != '0 && !fixed_slots[ej_idx]) begin
            eject_stb  <= 1'b1;
            eject_slot <= ej_idx;
          end
          default: ;
        endcase
      end
      if (hot_evt) begin
        sts_hp <= 1'b1;
        up_q   <= evt_insert  ? (SLOTS'(1) << evt_slot) : '0;
        dn_q   <= !evt_insert ? (SLOTS'(1) << evt_slot) : '0;
      end
    end
  end

  assign gpe_irq = sts_hp && en0[HP_BIT];

  always_comb begin
    case (reg_addr)
      A_STS0:  reg_rdata = SLOTS'({7'b0, sts_hp}) << HP_BIT;
      A_STS1:  reg_rdata = '0;
      A_EN0:   reg_rdata = SLOTS'(en0);
      A_EN1:   reg_rdata = SLOTS'(en1);
      A_UP:    reg_rdata = up_q;
      A_DN:    reg_rdata = dn_q;
      A_RM:    reg_rdata = ~fixed_slots;
      default: reg_rdata = '0;
    endcase
  end

  assert_evt_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt |=> sts_hp);
  assert_one_slot_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt |=> $countones(up_q | dn_q) == 1);
  assert_cold_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_insert && evt_cold && !reg_wr) |=> ($stable(up_q) && $stable(dn_q) && $stable(sts_hp)));
  assert_eject_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eject_stb |-> $past(reg_wr && reg_addr == A_EJ && reg_wdata != '0));
  assert_eject_not_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eject_stb |-> !$past(fixed_slots[eject_slot]));
  assert_zero_eject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EJ && reg_wdata == '0) |=> !eject_stb);
endmodule

// File: tb/hotplug_evt_ctrl_test.sv
module hotplug_evt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIXED = 32'h8000_0024;

  logic        clk = 0, rst_n = 0;
  logic        evt_valid = 0, evt_insert = 0, evt_cold = 0, reg_wr = 0;
  logic [4:0]  evt_slot = 0, reg_addr = 0, eject_slot;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        gpe_irq, eject_stb;
  int checks = 0, fails = 0, cyc = 0;

  logic [7:0]  m_sts0, m_en0, m_en1;
  logic [31:0] m_up, m_dn;
  logic        m_ejv;
  logic [4:0]  m_ejs;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotplug_evt_ctrl uut (.clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_insert(evt_insert), .evt_cold(evt_cold), .fixed_slots(FIXED), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpe_irq(gpe_irq),
    .eject_stb(eject_stb), .eject_slot(eject_slot));

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'd0: return {24'b0, m_sts0};
      5'd2: return {24'b0, m_en0};
      5'd3: return {24'b0, m_en1};
      5'd16: return m_up;
      5'd20: return m_dn;
      5'd28: return ~FIXED;
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic [4:0] lsb(input logic [31:0] d);
    for (int i = 0; i < 32; i++) if (d[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, m_read(a));
  endtask

  task automatic tick(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input logic ev, input logic [4:0] s, input logic ins, input logic cold);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    evt_valid = ev; evt_slot = s; evt_insert = ins; evt_cold = cold;
    @(posedge clk);
    m_ejv = 0;
    if (wr) case (a)
      5'd0: m_sts0 = m_sts0 & ~d[7:0];
      5'd2: m_en0 = d[7:0];
      5'd3: m_en1 = d[7:0];
      5'd16: m_up = d;
      5'd20: m_dn = d;
      5'd24: if (d != 0 && !FIXED[lsb(d)]) begin m_ejv = 1; m_ejs = lsb(d); end
      default: ;
    endcase
    if (ev && !(ins && cold)) begin
      m_sts0[1] = 1'b1;
      m_up = ins ? (32'd1 << s) : 32'd0;
      m_dn = ins ? 32'd0 : (32'd1 << s);
    end
    @(negedge clk);
    reg_wr = 0; evt_valid = 0;
    check("R3 irq", {31'b0, gpe_irq}, {31'b0, m_sts0[1] & m_en0[1]});
    check("R8 eject_stb", {31'b0, eject_stb}, {31'b0, m_ejv});
    if (m_ejv) check("R8 eject_slot", {27'b0, eject_slot}, {27'b0, m_ejs});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_sts0 = 0; m_en0 = 0; m_en1 = 0; m_up = 0; m_dn = 0; m_ejv = 0; m_ejs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'd0, "R1"); rd(5'd2, "R1"); rd(5'd16, "R1"); rd(5'd20, "R1");
    check("R1 irq", {31'b0, gpe_irq}, 32'd0);
    check("R1 eject", {31'b0, eject_stb}, 32'd0);
    // R10 removable mask, write ignored
    rd(5'd28, "R10");
    tick(1, 5'd28, 32'h0, 0, 0, 0, 0);
    rd(5'd28, "R10"); rd(5'd16, "R10"); rd(5'd0, "R10");
    // R4 insertion at top slot, enable interrupt
    tick(1, 5'd2, 32'h02, 0, 0, 0, 0); rd(5'd2, "R2");
    tick(0, 0, 0, 1, 5'd31, 1, 0);
    rd(5'd16, "R4"); rd(5'd20, "R4"); rd(5'd0, "R4");
    check("R3 irq set", {31'b0, gpe_irq}, 32'd1);
    // R5 removal at slot 0
    tick(0, 0, 0, 1, 5'd0, 0, 0);
    rd(5'd20, "R5"); rd(5'd16, "R5");
    // R2 W1C: write 0 keeps, write 0x02 clears
    tick(1, 5'd0, 32'h0, 0, 0, 0, 0); rd(5'd0, "R2");
    tick(1, 5'd0, 32'h02, 0, 0, 0, 0); rd(5'd0, "R2");
    check("R3 irq clear", {31'b0, gpe_irq}, 32'd0);
    // R6 coldplug
    tick(0, 0, 0, 1, 5'd7, 1, 1);
    rd(5'd16, "R6"); rd(5'd20, "R6"); rd(5'd0, "R6");
    // R7 collisions
    tick(1, 5'd16, 32'hFFFF_0000, 1, 5'd3, 1, 0); rd(5'd16, "R7");
    tick(1, 5'd0, 32'hFF, 1, 5'd9, 0, 0); rd(5'd0, "R7");
    // R8 eject cases
    tick(1, 5'd24, 32'h30, 0, 0, 0, 0); rd(5'd24, "R8");
    tick(1, 5'd24, 32'hA0, 0, 0, 0, 0);
    tick(1, 5'd24, 32'h8000_0000, 0, 0, 0, 0);
    // R9 zero eject
    tick(1, 5'd24, 32'h0, 0, 0, 0, 0);
    // R11 unmapped
    rd(5'd9, "R11"); rd(5'd1, "R11");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] a;
      logic [31:0] d;
      case ($urandom % 8)
        0: a = 5'd0; 1: a = 5'd2; 2: a = 5'd3; 3: a = 5'd16;
        4: a = 5'd20; 5: a = 5'd24; 6: a = 5'd28; default: a = 5'($urandom);
      endcase
      d = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : $urandom;
      tick(($urandom % 2) == 1, a, d, ($urandom % 3) == 0, 5'($urandom),
           ($urandom % 2) == 1, ($urandom % 4) == 0);
      rd(5'($urandom), "R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule